// File: doc/BRIEF.md
# Multi-Cycle Fetch and Decode Sequencer

This block is the control unit of a small 16-bit processor with four general registers and a byte-wide memory. It reads one opcode byte at the instruction pointer. It splits the byte into a class field, a register field and an operand-mode field. When the mode calls for it, the block reads a 16-bit little-endian value that follows the opcode. It then forms an effective address, moves or combines data, and advances the instruction pointer. Each step of this work takes its own clock cycle, so the time an instruction takes depends on how its operand is reached.

The memory port is synchronous. An address driven in one cycle returns its byte on `mem_rdata` in the next cycle. Writes take effect at the clock edge while `mem_we` is high. The block shows its status (stopped, paused, illegal opcode) and a debug view of the instruction pointer and all four registers, so that a test environment can watch program results.

Top module: `fd_seq16`

## Requirements
- R1: After reset the instruction pointer and all four registers read zero, and stopped, paused and illegal are all low.
- R2: An opcode byte is {class[7:5], reg[4:3], mode[2:0]}. Register codes are 0 = ax, 1 = bx, 2 = cx, 3 = dx. Modes 000–011 select those registers as the source. Class 110 copies the source into the register field, so 0xC1 copies bx into ax.
- R3: Classes 001 (or), 010 (and), 100 (subtract, modulo 2^16) and 101 (add, modulo 2^16) write reg OP source back into the register field.
- R4: Class 011 compares the register field with the source and records unsigned below and equal, and it writes no register. Special class 000 with sub-field 01 is a jump with a 16-bit target. Mode 000 = equal, 001 = not equal, 010 = below, 011 = below or equal, 100 = above, 101 = above or equal, 110 = always. A taken jump loads the target into the instruction pointer. A jump that is not taken falls through.
- R5: Mode 111 takes the two bytes after the opcode as a constant, low byte first. Mode 110 treats them as an address and reads a 16-bit word there, low byte at the address and high byte at the address plus one.
- R6: Mode 100 uses bx as the address. Mode 101 uses bx plus the 16-bit value after the opcode as the address.
- R7: Class 111 stores the register field to the memory operand, low byte at the effective address and high byte at the next address. The write strobe is only high during store or invert write cycles.
- R8: Special sub-field 10 inverts every bit of the operand named by the mode, either a register or a memory word.
- R9: Counting from the first cycle of the fetch, an instruction takes 3 cycles with a register source, 6 with a constant, 7 with [bx], 9 with a direct address and 11 with [address+bx]. A store to a direct address takes 7 cycles. A stop opcode takes 2 cycles before stopped is high.
- R10: Special sub-field 00 selects a zero-operand group. Mode 000 stops the processor for good, with the instruction pointer left one past the opcode and all state frozen. Mode 001 pauses until `restart` is high for a cycle, and execution then resumes at the next opcode. Other modes of the group do nothing.
- R11: Sub-field 11, jump mode 111, store with mode 111 and invert with mode 111 are illegal. Any of these raises illegal and stopped, writes no register, and leaves the instruction pointer one past the opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Resumes execution from the paused state |
| mem_addr | output | 16 | Byte address of the memory access |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the cycle after its address |
| halted | output | 1 | Processor stopped |
| paused | output | 1 | Processor waiting for restart |
| illegal | output | 1 | Stop was caused by an illegal opcode |
| dbg_ip | output | 16 | Instruction pointer |
| dbg_ax | output | 16 | Register ax |
| dbg_bx | output | 16 | Register bx |
| dbg_cx | output | 16 | Register cx |
| dbg_dx | output | 16 | Register dx |

## Verification
The checker tests the status rules on every cycle. A stop persists and freezes the instruction pointer and ax. A pause holds until restart and ends right after it. Illegal always comes with a stop. The write strobe never rises while the processor is stopped or paused. Only the bench's programs can show the data results and the cycle counts. The bench sweeps every arithmetic class over every destination and source register pair. It runs every jump condition against below, equal and above operand pairs. It runs each addressing mode, stores and memory inversion, and each illegal opcode form.

// File: rtl/fd_seq16.sv
module fd_seq16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        halted,
  output logic        paused,
  output logic        illegal,
  output logic [15:0] dbg_ip,
  output logic [15:0] dbg_ax,
  output logic [15:0] dbg_bx,
  output logic [15:0] dbg_cx,
  output logic [15:0] dbg_dx
);
  typedef enum logic [3:0] {
    S_FETCH, S_DEC, S_OPL, S_OPH, S_OPX, S_BXF, S_ADD, S_RDL,
    S_RDH, S_RDX, S_WRL, S_WRH, S_EXE, S_PAUSE, S_STOP
  } st_t;

  st_t         st, nx;
  logic [15:0] ip, ea, opv;
  logic [7:0]  op;
  logic        fl_lt, fl_eq, ill;
  logic [15:0] rf [4];

  logic [7:0]  ob;
  logic [2:0]  cls, md;
  logic [1:0]  rr;
  logic        is_spec, is_zop, is_jmp, is_not, uses_md, bad, need_imm, take;
  logic [15:0] src, wval, dst;
  st_t         mem_nx;

  assign ob       = (st == S_DEC) ? mem_rdata : op;
  assign cls      = ob[7:5];
  assign rr       = ob[4:3];
  assign md       = ob[2:0];
  assign is_spec  = cls == 3'd0;
  assign is_zop   = is_spec && rr == 2'd0;
  assign is_jmp   = is_spec && rr == 2'd1;
  assign is_not   = is_spec && rr == 2'd2;
  assign uses_md  = !is_spec || is_not;
  assign bad      = (is_spec && rr == 2'd3) || (is_jmp && md == 3'd7) ||
                    ((cls == 3'd7 || is_not) && md == 3'd7);
  assign need_imm = is_jmp || (uses_md && md >= 3'd5);
  assign mem_nx   = (cls == 3'd7) ? S_WRL : S_RDL;
  assign src      = md[2] ? opv : rf[md[1:0]];
  assign dst      = rf[rr];
  assign wval     = is_not ? ~opv : dst;

  always_comb begin
    case (md)
      3'd0:    take = fl_eq;
      3'd1:    take = !fl_eq;
      3'd2:    take = fl_lt;
      3'd3:    take = fl_lt || fl_eq;
      3'd4:    take = !fl_lt && !fl_eq;
      3'd5:    take = !fl_lt;
      3'd6:    take = 1'b1;
      default: take = 1'b0;
    endcase
  end

  always_comb begin
    nx = st;
    case (st)
      S_FETCH: nx = S_DEC;
      S_DEC: begin
        if (bad)                  nx = S_STOP;
        else if (is_zop)          nx = (md == 3'd0) ? S_STOP : (md == 3'd1) ? S_PAUSE : S_FETCH;
        else if (need_imm)        nx = S_OPL;
        else if (uses_md && md == 3'd4) nx = S_BXF;
        else                      nx = S_EXE;
      end
      S_OPL: nx = S_OPH;
      S_OPH: nx = S_OPX;
      S_OPX: begin
        if (uses_md && md == 3'd5)      nx = S_BXF;
        else if (uses_md && md == 3'd6) nx = mem_nx;
        else                            nx = S_EXE;
      end
      S_BXF:   nx = (md == 3'd5) ? S_ADD : mem_nx;
      S_ADD:   nx = mem_nx;
      S_RDL:   nx = S_RDH;
      S_RDH:   nx = S_RDX;
      S_RDX:   nx = is_not ? S_WRL : S_EXE;
      S_WRL:   nx = S_WRH;
      S_WRH:   nx = S_FETCH;
      S_EXE:   nx = S_FETCH;
      S_PAUSE: nx = restart ? S_FETCH : S_PAUSE;
      default: nx = S_STOP;
    endcase
  end

  always_comb begin
    case (st)
      S_OPH:          mem_addr = ip + 16'd1;
      S_RDL, S_WRL:   mem_addr = ea;
      S_RDH, S_WRH:   mem_addr = ea + 16'd1;
      default:        mem_addr = ip;
    endcase
  end

  assign mem_we    = (st == S_WRL) || (st == S_WRH);
  assign mem_wdata = (st == S_WRH) ? wval[15:8] : wval[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_FETCH;
      ip    <= '0;
      ea    <= '0;
      opv   <= '0;
      op    <= '0;
      fl_lt <= 1'b0;
      fl_eq <= 1'b0;
      ill   <= 1'b0;
      for (int i = 0; i < 4; i++) rf[i] <= '0;
    end else begin
      st <= nx;
      case (st)
        S_DEC: begin
          op <= mem_rdata;
          ip <= ip + 16'd1;
          if (bad) ill <= 1'b1;
        end
        S_OPH: opv[7:0] <= mem_rdata;
        S_OPX: begin
          opv[15:8] <= mem_rdata;
          ea        <= {mem_rdata, opv[7:0]};
          ip        <= ip + 16'd2;
        end
        S_BXF: ea <= rf[1];
        S_ADD: ea <= ea + opv;
        S_RDH: opv[7:0]  <= mem_rdata;
        S_RDX: opv[15:8] <= mem_rdata;
        S_EXE: begin
          if (is_jmp) begin
            if (take) ip <= opv;
          end else if (is_not) begin
            rf[md[1:0]] <= ~rf[md[1:0]];
          end else begin
            case (cls)
              3'd1: rf[rr] <= dst | src;
              3'd2: rf[rr] <= dst & src;
              3'd3: begin
                fl_lt <= dst < src;
                fl_eq <= dst == src;
              end
              3'd4: rf[rr] <= dst - src;
              3'd5: rf[rr] <= dst + src;
              3'd6: rf[rr] <= src;
              default: ;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  assign halted  = st == S_STOP;
  assign paused  = st == S_PAUSE;
  assign illegal = ill;
  assign dbg_ip  = ip;
  assign dbg_ax  = rf[0];
  assign dbg_bx  = rf[1];
  assign dbg_cx  = rf[2];
  assign dbg_dx  = rf[3];
endmodule

// File: rtl/fd_seq16_chk.sv
module fd_seq16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        restart,
  input logic        mem_we,
  input logic        halted,
  input logic        paused,
  input logic        illegal,
  input logic [15:0] dbg_ip,
  input logic [15:0] dbg_ax
);
  AST_STOP_STICKY:   assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted); // R10
  AST_STOP_FROZEN:   assert property (@(posedge clk) disable iff (!rst_n) halted |=> $stable(dbg_ip) && $stable(dbg_ax)); // R10
  AST_PAUSE_HOLDS:   assert property (@(posedge clk) disable iff (!rst_n) paused && !restart |=> paused); // R10
  AST_PAUSE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) paused && restart |=> !paused); // R10
  AST_ONE_STOP_KIND: assert property (@(posedge clk) disable iff (!rst_n) !(halted && paused)); // R10
  AST_ILLEGAL_STOPS: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> halted); // R11
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> !halted && !paused); // R7
endmodule

bind fd_seq16 fd_seq16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .mem_we(mem_we),
  .halted(halted), .paused(paused), .illegal(illegal),
  .dbg_ip(dbg_ip), .dbg_ax(dbg_ax)
);

// File: tb/fd_seq16_tb.sv
module fd_seq16_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        halted, paused, illegal;
  logic [15:0] dbg_ip, dbg_ax, dbg_bx, dbg_cx, dbg_dx;

  logic [7:0] mem [256];
  int n_chk = 0;
  int n_fail = 0;
  int pc;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr[7:0]];
    if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
  end

  fd_seq16 u_dut (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted), .paused(paused), .illegal(illegal),
    .dbg_ip(dbg_ip), .dbg_ax(dbg_ax), .dbg_bx(dbg_bx), .dbg_cx(dbg_cx), .dbg_dx(dbg_dx)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    pc = 0;
  endtask

  task automatic e1(input logic [7:0] b);
    mem[pc] = b;
    pc++;
  endtask

  task automatic e3(input logic [7:0] b, input logic [15:0] w);
    e1(b); e1(w[7:0]); e1(w[15:8]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(output int cyc);
    cyc = 0;
    do begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end while (!halted && !paused && cyc < 2000);
    if (cyc >= 2000) chk("run timeout", 16'd1, 16'd0);
  endtask

  function automatic logic [15:0] rd(input int r);
    case (r)
      0: return dbg_ax;
      1: return dbg_bx;
      2: return dbg_cx;
      default: return dbg_dx;
    endcase
  endfunction

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] v [4];
    logic [15:0] exp;
    v[0] = 16'hF00F; v[1] = 16'h0FF1; v[2] = 16'h8001; v[3] = 16'h00FF;

    // R1 reset state
    clr();
    do_reset();
    chk("R1 ip", dbg_ip, 16'h0);
    chk("R1 ax", dbg_ax, 16'h0);
    chk("R1 bx", dbg_bx, 16'h0);
    chk("R1 cx", dbg_cx, 16'h0);
    chk("R1 dx", dbg_dx, 16'h0);
    chk("R1 status", {13'd0, halted, paused, illegal}, 16'h0);

    // R2 R3 R4 sweep over ALU classes and register pairs
    for (int c = 1; c <= 6; c++) begin
      for (int d = 0; d < 4; d++) begin
        for (int s = 0; s < 4; s++) begin
          clr();
          e3(8'hC7, v[0]); e3(8'hCF, v[1]); e3(8'hD7, v[2]); e3(8'hDF, v[3]);
          e1({c[2:0], d[1:0], 1'b0, s[1:0]});
          e1(8'h00);
          do_reset();
          run(cyc);
          case (c)
            1: exp = v[d] | v[s];
            2: exp = v[d] & v[s];
            3: exp = v[d];
            4: exp = v[d] - v[s];
            5: exp = v[d] + v[s];
            default: exp = v[s];
          endcase
          if (c == 6)      chk("R2 copy", rd(d), exp);
          else if (c == 3) chk("R4 compare writes nothing", rd(d), exp);
          else             chk("R3 alu", rd(d), exp);
          if (d == 0 && s == 1) chk("R9 reg source cycles", cyc[15:0], 16'd29);
        end
      end
    end

    // R4 jump conditions
    for (int p = 0; p < 4; p++) begin
      for (int cnd = 0; cnd < 7; cnd++) begin
        logic [15:0] a, b;
        logic t;
        a = (p == 0) ? 16'd5 : (p == 1) ? 16'd3 : (p == 2) ? 16'd9 : 16'hFFFF;
        b = (p == 0) ? 16'd5 : (p == 1) ? 16'd9 : (p == 2) ? 16'd3 : 16'd1;
        case (cnd)
          0: t = a == b;
          1: t = a != b;
          2: t = a < b;
          3: t = a <= b;
          4: t = a > b;
          5: t = a >= b;
          default: t = 1'b1;
        endcase
        clr();
        e3(8'hC7, a); e3(8'hCF, b); e1(8'h61);
        e3({5'b00001, cnd[2:0]}, 16'd14);
        e3(8'hD7, 16'd1); e1(8'h00);
        e3(8'hD7, 16'd2); e1(8'h00);
        do_reset();
        run(cyc);
        chk("R4 jump", dbg_cx, t ? 16'd2 : 16'd1);
      end
    end

    // R5 direct address read, R9 cycles
    clr();
    e3(8'hC6, 16'h0080); e1(8'h00);
    mem[8'h80] = 8'h34; mem[8'h81] = 8'h12;
    do_reset(); run(cyc);
    chk("R5 direct read", dbg_ax, 16'h1234);
    chk("R9 direct cycles", cyc[15:0], 16'd11);

    // R5 constant, R9 constant cycles
    clr();
    e3(8'hDF, 16'hBEEF); e1(8'h00);
    do_reset(); run(cyc);
    chk("R5 constant", dbg_dx, 16'hBEEF);
    chk("R9 constant cycles", cyc[15:0], 16'd8);

    // R6 [bx]
    clr();
    e3(8'hCF, 16'h0080); e1(8'hD4); e1(8'h00);
    mem[8'h80] = 8'h34; mem[8'h81] = 8'h12;
    do_reset(); run(cyc);
    chk("R6 bx indirect", dbg_cx, 16'h1234);
    chk("R9 bx indirect cycles", cyc[15:0], 16'd15);

    // R6 [xxxx+bx]
    clr();
    e3(8'hCF, 16'h0002); e3(8'hDD, 16'h007E); e1(8'h00);
    mem[8'h80] = 8'h34; mem[8'h81] = 8'h12;
    do_reset(); run(cyc);
    chk("R6 indexed", dbg_dx, 16'h1234);
    chk("R9 indexed cycles", cyc[15:0], 16'd19);

    // R7 store direct and via bx
    clr();
    e3(8'hC7, 16'hABCD); e3(8'hE6, 16'h0090); e1(8'h00);
    do_reset(); run(cyc);
    chk("R7 store low", {8'h00, mem[8'h90]}, 16'h00CD);
    chk("R7 store high", {8'h00, mem[8'h91]}, 16'h00AB);
    chk("R9 store cycles", cyc[15:0], 16'd15);
    clr();
    e3(8'hCF, 16'h00A0); e1(8'hEC); e1(8'h00);
    mem[8'hA1] = 8'h55;
    do_reset(); run(cyc);
    chk("R7 store via bx", {mem[8'hA1], mem[8'hA0]}, 16'h00A0);

    // R8 invert register and memory
    clr();
    e3(8'hD7, 16'h0F0F); e1(8'h12); e1(8'h00);
    do_reset(); run(cyc);
    chk("R8 invert reg", dbg_cx, 16'hF0F0);
    clr();
    e3(8'h16, 16'h0080); e1(8'h00);
    mem[8'h80] = 8'h34; mem[8'h81] = 8'h12;
    do_reset(); run(cyc);
    chk("R8 invert mem", {mem[8'h81], mem[8'h80]}, 16'hEDCB);

    // R10 pause and restart, stop freeze
    clr();
    e3(8'hC7, 16'd5); e1(8'h01); e3(8'hCF, 16'd7); e1(8'h00);
    do_reset(); run(cyc);
    chk("R10 paused", {15'd0, paused}, 16'd1);
    chk("R10 paused bx", dbg_bx, 16'd0);
    chk("R10 paused ip", dbg_ip, 16'd4);
    repeat (5) @(negedge clk);
    chk("R10 still paused", {15'd0, paused}, 16'd1);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    run(cyc);
    chk("R10 resumed bx", dbg_bx, 16'd7);
    chk("R10 stop ip", dbg_ip, 16'd8);
    repeat (5) @(negedge clk);
    chk("R10 stop frozen", {15'd0, halted}, 16'd1);
    chk("R10 stop ip frozen", dbg_ip, 16'd8);
    clr();
    e3(8'hC7, 16'd5); e1(8'h03); e1(8'h00);
    do_reset(); run(cyc);
    chk("R10 no-op ax", dbg_ax, 16'd5);
    chk("R10 no-op ip", dbg_ip, 16'd5);
    chk("R10 no-op not illegal", {15'd0, illegal}, 16'd0);

    // R11 illegal forms
    for (int k = 0; k < 4; k++) begin
      logic [7:0] bop;
      bop = (k == 0) ? 8'h18 : (k == 1) ? 8'h0F : (k == 2) ? 8'hE7 : 8'h17;
      clr();
      e1(bop); e3(8'hC7, 16'h1111);
      do_reset(); run(cyc);
      chk("R11 illegal flag", {14'd0, illegal, halted}, 16'd3);
      chk("R11 illegal ip", dbg_ip, 16'd1);
      chk("R11 illegal ax", dbg_ax, 16'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule